// File: doc/BRIEF.md
# Streaming Defective Pixel Corrector

This stage sits in a raw Bayer pixel stream. It finds isolated dead, stuck or hot sensor sites as they go by and replaces them, with no stored defect table and no frame buffer. Pixels enter on an AXI4-Stream slave port. The start-of-frame flag travels on tuser and the end-of-line flag on tlast. A small store of six rows, each as wide as the image, lets the block read the 5×5 neighbourhood of each pixel. For every pixel it compares the centre with its eight same-colour sites, which lie two positions away horizontally, vertically and on both diagonals. The centre is treated as defective only when it is brighter than all eight, or darker than all eight, by more than a programmable margin. A defective pixel takes the average of the opposite pair of neighbours whose two values are closest to each other.

The frame size is fixed by parameters. Any window position that falls outside the picture takes the value of the nearest pixel inside it. Results leave in raster order on an AXI4-Stream master port, two lines plus two pixels behind the input. Each output keeps the tuser and tlast bits that arrived with it. When the consumer stalls, the whole path stops. After each frame the block reports how many pixels it replaced in that frame.

Top module: `dpc_top`

## Requirements
- R1: After reset, m_tvalid is 0, fix_count is 0 and s_tready is 1.
- R2: A pixel is replaced when its value exceeds every one of its eight neighbours, taken at row and column offsets of 0 or ±2 (the centre excluded), by more than thresh.
- R3: A pixel is also replaced when its value is below every one of those eight neighbours by more than thresh.
- R4: A pixel with at least one neighbour inside the margin, or with neighbours on both sides of it, leaves with its value unchanged.
- R5: A replaced pixel becomes floor((a+b)/2) of one opposite pair (a, b). The pair chosen is the one with the smallest |a−b|. On a tie, the first pair in this order wins: horizontal (left/right), vertical (up/down), down-right diagonal (up-left/down-right), anti-diagonal (up-right/down-left).
- R6: A window position outside the frame uses the pixel at the row and column clamped into [0, IMG_H−1] and [0, IMG_W−1].
- R7: Output pixel j of a frame is not presented until input pixel j+2·IMG_W+2 of that frame has been accepted. The exception is the tail of the frame, which is presented once the whole frame has been accepted.
- R8: m_tuser and m_tlast of each output pixel equal the s_tuser and s_tlast that arrived with the same pixel.
- R9: While m_tvalid is 1 and m_tready is 0, m_tvalid stays 1 and m_tdata, m_tuser and m_tlast stay unchanged. Every pixel of a frame leaves exactly once, in raster order.
- R10: fix_count equals the number of pixels replaced in the most recently completed frame. It changes only when the last pixel of a frame moves into the output register.
- R11: The comparison is strict. A difference exactly equal to thresh does not count as exceeding it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thresh | input | DW | Detection margin; hold steady during a frame |
| s_tdata | input | DW | Input pixel |
| s_tuser | input | 1 | Input start-of-frame flag |
| s_tlast | input | 1 | Input end-of-line flag |
| s_tvalid | input | 1 | Input pixel valid |
| s_tready | output | 1 | Block can accept an input pixel |
| m_tdata | output | DW | Output pixel |
| m_tuser | output | 1 | Output start-of-frame flag |
| m_tlast | output | 1 | Output end-of-line flag |
| m_tvalid | output | 1 | Output pixel valid |
| m_tready | input | 1 | Consumer can take the output pixel |
| fix_count | output | $clog2(IMG_W·IMG_H+1) | Replacements in the last completed frame |

## Verification
The bench builds the block with 8-bit pixels and an 8×7 frame. At that size every pixel position is checked, including all clamped border bands, in many frames. Seven rows against six row slots make the slot index wrap inside each frame. The 18-pixel lag is about a third of the 56-pixel frame, so both the lag limit and the end-of-frame drain happen often, and random input gaps and output stalls hit them in many phases. Injected spikes, exact-margin cases, mixed-sign neighbourhoods and random thresholds reach every detection outcome and every pair-selection branch.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  // widest pixel the arithmetic helpers handle (DW must stay at or below PXW-1)
  localparam int PXW = 16;
  typedef logic [PXW-1:0] px_t;

  typedef enum logic [1:0] {DIR_HOR, DIR_VER, DIR_DIAG, DIR_ANTI} dir_e;

  function automatic px_t abs_gap(px_t a, px_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic px_t mean2(px_t a, px_t b);
    logic [PXW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[PXW:1];
  endfunction

  // smallest gradient wins; an earlier direction keeps a tie
  function automatic dir_e flattest(px_t gh, px_t gv, px_t gd, px_t ga);
    dir_e best;
    px_t  low;
    best = DIR_HOR;
    low  = gh;
    if (gv < low) begin best = DIR_VER;  low = gv; end
    if (gd < low) begin best = DIR_DIAG; low = gd; end
    if (ga < low) begin best = DIR_ANTI; end
    return best;
  endfunction

  function automatic int clamp_to(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/dpc_rowstore.sv
module dpc_rowstore #(
  parameter int PW    = 12,
  parameter int COLS  = 64,
  parameter int SLOTS = 6,
  parameter int NTAP  = 9,
  localparam int SW = $clog2(SLOTS),
  localparam int XW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_slot,
  input  logic [XW-1:0]      wr_col,
  input  logic [PW-1:0]      wr_word,
  input  logic [NTAP*SW-1:0] rd_slot,
  input  logic [NTAP*XW-1:0] rd_col,
  output logic [NTAP*PW-1:0] rd_word
);
  logic [PW-1:0] rows [SLOTS][COLS];

  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_slot][wr_col] <= wr_word;
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign rd_word[t*PW +: PW] = rows[rd_slot[t*SW +: SW]][rd_col[t*XW +: XW]];
  end
endmodule

// File: rtl/dpc_ctrl.sv
module dpc_ctrl #(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int SLOTS = 6,
  localparam int NPIX = IMG_W * IMG_H,
  localparam int LAG  = 2 * IMG_W + 2,
  localparam int CW   = $clog2(NPIX + LAG + 2),
  localparam int SW   = $clog2(SLOTS),
  localparam int XW   = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int YW   = (IMG_H > 1) ? $clog2(IMG_H) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_fire,
  input  logic          out_load,
  output logic          in_ready,
  output logic          out_avail,
  output logic          out_is_last,
  output logic [SW-1:0] wr_slot,
  output logic [XW-1:0] wr_col,
  output logic [SW-1:0] rd_slot,
  output logic [XW-1:0] rd_col,
  output logic [YW-1:0] rd_row
);
  localparam logic [CW-1:0] NPIX_C = CW'(NPIX);
  localparam logic [CW-1:0] LAG_C  = CW'(LAG);
  localparam logic [XW-1:0] XLAST  = XW'(IMG_W - 1);
  localparam logic [SW-1:0] SLAST  = SW'(SLOTS - 1);

  logic [CW-1:0] in_cnt, out_cnt;

  // one pixel of slack beyond the lag keeps six row slots collision free
  assign in_ready    = (in_cnt < NPIX_C) && (in_cnt <= out_cnt + LAG_C + CW'(1));
  assign out_avail   = (in_cnt > out_cnt + LAG_C) || (in_cnt == NPIX_C);
  assign out_is_last = (out_cnt == NPIX_C - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt  <= '0;
      wr_col  <= '0;
      wr_slot <= '0;
    end else if (out_load && out_is_last) begin
      in_cnt  <= '0;
      wr_col  <= '0;
      wr_slot <= '0;
    end else if (in_fire) begin
      in_cnt <= in_cnt + CW'(1);
      if (wr_col == XLAST) begin
        wr_col  <= '0;
        wr_slot <= (wr_slot == SLAST) ? '0 : wr_slot + SW'(1);
      end else begin
        wr_col <= wr_col + XW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      rd_col  <= '0;
      rd_row  <= '0;
      rd_slot <= '0;
    end else if (out_load) begin
      if (out_is_last) begin
        out_cnt <= '0;
        rd_col  <= '0;
        rd_row  <= '0;
        rd_slot <= '0;
      end else begin
        out_cnt <= out_cnt + CW'(1);
        if (rd_col == XLAST) begin
          rd_col  <= '0;
          rd_row  <= rd_row + YW'(1);
          rd_slot <= (rd_slot == SLAST) ? '0 : rd_slot + SW'(1);
        end else begin
          rd_col <= rd_col + XW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dpc_detect.sv
module dpc_detect
  import dpc_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic [DW-1:0]   centre,
  input  logic [8*DW-1:0] ring,    // up-left, up, up-right, left, right, down-left, down, down-right
  input  logic [DW-1:0]   margin,
  output logic            defect,
  output logic [DW-1:0]   repair
);
  px_t c, m, n, ul, up, ur, lf, rt, dl, dn, dr;
  logic above_all, below_all;
  dir_e pick;
  px_t  fill;

  always_comb begin
    c = PXW'(centre);
    m = PXW'(margin);
    above_all = 1'b1;
    below_all = 1'b1;
    for (int k = 0; k < 8; k++) begin
      n = PXW'(ring[k*DW +: DW]);
      if (!(c > n + m)) above_all = 1'b0;
      if (!(c + m < n)) below_all = 1'b0;
    end
    defect = above_all || below_all;
  end

  always_comb begin
    ul = PXW'(ring[0*DW +: DW]);
    up = PXW'(ring[1*DW +: DW]);
    ur = PXW'(ring[2*DW +: DW]);
    lf = PXW'(ring[3*DW +: DW]);
    rt = PXW'(ring[4*DW +: DW]);
    dl = PXW'(ring[5*DW +: DW]);
    dn = PXW'(ring[6*DW +: DW]);
    dr = PXW'(ring[7*DW +: DW]);
    pick = flattest(abs_gap(lf, rt), abs_gap(up, dn), abs_gap(ul, dr), abs_gap(ur, dl));
    unique case (pick)
      DIR_HOR:  fill = mean2(lf, rt);
      DIR_VER:  fill = mean2(up, dn);
      DIR_DIAG: fill = mean2(ul, dr);
      default:  fill = mean2(ur, dl);
    endcase
    repair = DW'(fill);
  end
endmodule

// File: rtl/dpc_top.sv
module dpc_top
  import dpc_pkg::*;
#(
  parameter int DW    = 10,
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int FCW  = $clog2(IMG_W * IMG_H + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  thresh,
  input  logic [DW-1:0]  s_tdata,
  input  logic           s_tuser,
  input  logic           s_tlast,
  input  logic           s_tvalid,
  output logic           s_tready,
  output logic [DW-1:0]  m_tdata,
  output logic           m_tuser,
  output logic           m_tlast,
  output logic           m_tvalid,
  input  logic           m_tready,
  output logic [FCW-1:0] fix_count
);
  localparam int SLOTS = 6;
  localparam int NTAP  = 9;
  localparam int PW    = DW + 2;
  localparam int SW    = $clog2(SLOTS);
  localparam int XW    = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int YW    = (IMG_H > 1) ? $clog2(IMG_H) : 1;

  // named internal events, observed by the bound checker
  logic            load_evt;
  logic            corr_evt;
  logic            last_load;
  logic [DW-1:0]   win_ctr;
  logic [8*DW-1:0] win_ring;
  logic [DW-1:0]   fix_val;

  logic            in_fire, avail, is_last;
  logic [SW-1:0]   wr_slot, rd_slot;
  logic [XW-1:0]   wr_col, rd_col;
  logic [YW-1:0]   rd_row;
  logic [NTAP*SW-1:0] tap_slot;
  logic [NTAP*XW-1:0] tap_col;
  logic [NTAP*PW-1:0] tap_word;
  logic [PW-1:0]   ctr_word;
  logic [FCW-1:0]  live_fixes;

  assign in_fire   = s_tvalid && s_tready;
  assign load_evt  = avail && (!m_tvalid || m_tready);
  assign last_load = load_evt && is_last;

  dpc_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H), .SLOTS(SLOTS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_fire    (in_fire),
    .out_load   (load_evt),
    .in_ready   (s_tready),
    .out_avail  (avail),
    .out_is_last(is_last),
    .wr_slot    (wr_slot),
    .wr_col     (wr_col),
    .rd_slot    (rd_slot),
    .rd_col     (rd_col),
    .rd_row     (rd_row)
  );

  // tap t sits at row offset 2*(t/3-1) and column offset 2*(t%3-1), clamped into the frame
  always_comb begin
    for (int t = 0; t < NTAP; t++) begin
      int rr, cc, sl;
      rr = clamp_to(int'(rd_row) + 2 * (t / 3 - 1), 0, IMG_H - 1);
      cc = clamp_to(int'(rd_col) + 2 * (t % 3 - 1), 0, IMG_W - 1);
      sl = (int'(rd_slot) + SLOTS + rr - int'(rd_row)) % SLOTS;
      tap_slot[t*SW +: SW] = SW'(sl);
      tap_col[t*XW +: XW]  = XW'(cc);
    end
  end

  dpc_rowstore #(.PW(PW), .COLS(IMG_W), .SLOTS(SLOTS), .NTAP(NTAP)) store_i (
    .clk    (clk),
    .wr_en  (in_fire),
    .wr_slot(wr_slot),
    .wr_col (wr_col),
    .wr_word({s_tuser, s_tlast, s_tdata}),
    .rd_slot(tap_slot),
    .rd_col (tap_col),
    .rd_word(tap_word)
  );

  assign ctr_word = tap_word[4*PW +: PW];
  assign win_ctr  = ctr_word[DW-1:0];

  for (genvar k = 0; k < 8; k++) begin : g_ring
    localparam int TAP = (k < 4) ? k : k + 1;
    assign win_ring[k*DW +: DW] = tap_word[TAP*PW +: DW];
  end

  dpc_detect #(.DW(DW)) detect_i (
    .centre(win_ctr),
    .ring  (win_ring),
    .margin(thresh),
    .defect(corr_evt),
    .repair(fix_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tuser  <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (load_evt) begin
      m_tvalid <= 1'b1;
      m_tdata  <= corr_evt ? fix_val : win_ctr;
      m_tuser  <= ctr_word[PW-1];
      m_tlast  <= ctr_word[PW-2];
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_fixes <= '0;
      fix_count  <= '0;
    end else if (last_load) begin
      fix_count  <= live_fixes + FCW'(corr_evt);
      live_fixes <= '0;
    end else if (load_evt) begin
      live_fixes <= live_fixes + FCW'(corr_evt);
    end
  end
endmodule

// File: rtl/dpc_top_chk.sv
module dpc_top_chk #(
  parameter int DW    = 10,
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  localparam int FCW  = $clog2(IMG_W * IMG_H + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [DW-1:0]  thresh,
  input logic           s_tvalid,
  input logic           s_tready,
  input logic [DW-1:0]  m_tdata,
  input logic           m_tuser,
  input logic           m_tlast,
  input logic           m_tvalid,
  input logic           m_tready,
  input logic [FCW-1:0] fix_count,
  input logic           load_evt,
  input logic           corr_evt,
  input logic           last_load,
  input logic [DW-1:0]  win_ctr,
  input logic [8*DW-1:0] win_ring,
  input logic [DW-1:0]  fix_val
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int LAG  = 2 * IMG_W + 2;

  logic [31:0]   seen_in, seen_out;
  logic [DW-1:0] ring_lo, ring_hi;
  logic          lag_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_in  <= '0;
      seen_out <= '0;
    end else begin
      if (s_tvalid && s_tready) seen_in  <= seen_in + 32'd1;
      if (m_tvalid && m_tready) seen_out <= seen_out + 32'd1;
    end
  end

  always_comb begin
    ring_lo = win_ring[DW-1:0];
    ring_hi = win_ring[DW-1:0];
    for (int k = 1; k < 8; k++) begin
      if (win_ring[k*DW +: DW] < ring_lo) ring_lo = win_ring[k*DW +: DW];
      if (win_ring[k*DW +: DW] > ring_hi) ring_hi = win_ring[k*DW +: DW];
    end
    lag_ok = (seen_in >= seen_out + 32'(LAG + 1)) ||
             (seen_in >= (seen_out / 32'(NPIX) + 32'd1) * 32'(NPIX));
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  assert_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready |-> lag_ok);

  assert_outlier_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && corr_evt |->
      ({1'b0, win_ctr} > {1'b0, ring_hi} + {1'b0, thresh}) ||
      ({1'b0, win_ctr} + {1'b0, thresh} < {1'b0, ring_lo}));

  assert_fill_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && corr_evt |-> fix_val >= ring_lo && fix_val <= ring_hi);

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !corr_evt |=> m_tdata == $past(win_ctr));

  assert_count_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fix_count) |-> $past(last_load));
endmodule

bind dpc_top dpc_top_chk #(.DW(DW), .IMG_W(IMG_W), .IMG_H(IMG_H)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .thresh   (thresh),
  .s_tvalid (s_tvalid),
  .s_tready (s_tready),
  .m_tdata  (m_tdata),
  .m_tuser  (m_tuser),
  .m_tlast  (m_tlast),
  .m_tvalid (m_tvalid),
  .m_tready (m_tready),
  .fix_count(fix_count),
  .load_evt (load_evt),
  .corr_evt (corr_evt),
  .last_load(last_load),
  .win_ctr  (win_ctr),
  .win_ring (win_ring),
  .fix_val  (fix_val)
);

// File: tb/dpc_top_tb_top.sv
`timescale 1ns/1ps
module dpc_top_tb_top;
  localparam int DW   = 8;
  localparam int W    = 8;
  localparam int H    = 7;
  localparam int NPIX = W * H;
  localparam int LAG  = 2 * W + 2;
  localparam int FCW  = $clog2(NPIX + 1);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [DW-1:0]  thresh = '0;
  logic [DW-1:0]  s_tdata = '0;
  logic           s_tuser = 1'b0, s_tlast = 1'b0, s_tvalid = 1'b0;
  logic           s_tready;
  logic [DW-1:0]  m_tdata;
  logic           m_tuser, m_tlast, m_tvalid;
  logic           m_tready = 1'b0;
  logic [FCW-1:0] fix_count;

  always #5 clk = ~clk;

  dpc_top #(.DW(DW), .IMG_W(W), .IMG_H(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .thresh(thresh),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .fix_count(fix_count)
  );

  int n_checks = 0;
  int n_bad    = 0;
  int img [NPIX];
  bit usr [NPIX];
  bit lst [NPIX];
  int thr;
  int total_cycles = 0;
  bit hung = 0;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int at(int r, int c);
    int rr = (r < 0) ? 0 : (r > H - 1) ? H - 1 : r;   // R6 clamp
    int cc = (c < 0) ? 0 : (c > W - 1) ? W - 1 : c;
    return img[rr * W + cc];
  endfunction

  // reference: outlier if beyond the whole neighbour span by more than the margin
  function automatic void expect_px(int idx, output int val, output bit fixed, output string tag);
    int r = idx / W, c = idx % W, ctr, lo, hi, best, g, a, b;
    int nb [8];
    int pa [4], pb [4];
    bit edge_eq = 0;
    ctr = img[idx];
    nb[0] = at(r-2, c-2); nb[1] = at(r-2, c); nb[2] = at(r-2, c+2); nb[3] = at(r, c-2);
    nb[4] = at(r, c+2);   nb[5] = at(r+2, c-2); nb[6] = at(r+2, c); nb[7] = at(r+2, c+2);
    lo = nb[0]; hi = nb[0];
    foreach (nb[k]) begin
      if (nb[k] < lo) lo = nb[k];
      if (nb[k] > hi) hi = nb[k];
      if (ctr - nb[k] == thr || nb[k] - ctr == thr) edge_eq = 1;
    end
    pa[0] = nb[3]; pb[0] = nb[4];
    pa[1] = nb[1]; pb[1] = nb[6];
    pa[2] = nb[0]; pb[2] = nb[7];
    pa[3] = nb[2]; pb[3] = nb[5];
    fixed = (ctr > hi + thr) || (ctr + thr < lo);
    val = ctr;
    if (fixed) begin
      best = 0;
      for (int p = 1; p < 4; p++) begin
        g = (pa[p] > pb[p]) ? pa[p] - pb[p] : pb[p] - pa[p];
        a = (pa[best] > pb[best]) ? pa[best] - pb[best] : pb[best] - pa[best];
        if (g < a) best = p;
      end
      val = (pa[best] + pb[best]) / 2;
    end
    if (fixed) tag = (ctr > hi) ? "R2/R5" : "R3/R5";
    else if (edge_eq) tag = "R11";
    else tag = "R4";
    if (r < 2 || r > H - 3 || c < 2 || c > W - 3) tag = {tag, " R6"};
  endfunction

  task automatic run_frame(int gap_pct, int stall_pct);
    int sent = 0, got = 0, cyc = 0, exp_fix = 0, ev;
    bit ef, held = 0;
    logic [DW-1:0] held_d;
    logic held_u, held_l;
    string tg;
    thresh = DW'(thr);
    while (got < NPIX) begin
      @(negedge clk);
      cyc++; total_cycles++;
      if (cyc > 20000) begin
        hung = 1;
        check(0, "watchdog", got, NPIX);
        break;
      end
      m_tready = ($urandom % 100) >= stall_pct;
      if (held) begin
        check(m_tvalid === 1'b1 && m_tdata === held_d && m_tuser === held_u && m_tlast === held_l,
              "R9", int'(m_tdata), int'(held_d));
      end
      held = 0;
      if (m_tvalid) begin
        if (m_tready) begin
          expect_px(got, ev, ef, tg);
          if (ef) exp_fix++;
          check(m_tdata === DW'(ev), $sformatf("%s pixel %0d", tg, got), int'(m_tdata), ev);
          check(m_tuser === usr[got] && m_tlast === lst[got], $sformatf("R8 pixel %0d", got),
                int'({m_tuser, m_tlast}), int'({usr[got], lst[got]}));
          check(sent >= ((got + LAG + 1 < NPIX) ? got + LAG + 1 : NPIX),
                $sformatf("R7 pixel %0d", got), sent, got + LAG + 1);
          got++;
        end else begin
          held = 1; held_d = m_tdata; held_u = m_tuser; held_l = m_tlast;
        end
      end
      if (sent < NPIX && ($urandom % 100) >= gap_pct) begin
        s_tvalid = 1'b1;
        s_tdata  = DW'(img[sent]);
        s_tuser  = usr[sent];
        s_tlast  = lst[sent];
        if (s_tready) sent++;
      end else begin
        s_tvalid = 1'b0;
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    m_tready = 1'b0;
    if (!hung) begin
      check(got == NPIX, "R9 count", got, NPIX);
      check(int'(fix_count) == exp_fix, "R10", int'(fix_count), exp_fix);
    end
  endtask

  task automatic std_marks();
    for (int i = 0; i < NPIX; i++) begin
      usr[i] = (i == 0);
      lst[i] = (i % W == W - 1);
    end
  endtask

  task automatic fill(int v);
    for (int i = 0; i < NPIX; i++) img[i] = v;
  endtask

  initial begin
    std_marks();
    repeat (3) @(negedge clk);
    check(m_tvalid === 1'b0, "R1 valid", int'(m_tvalid), 0);
    check(fix_count === '0, "R1 count", int'(fix_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(s_tready === 1'b1, "R1 ready", int'(s_tready), 1);

    // R2/R3: isolated bright and dark spikes on a flat field, incl. corners
    fill(100); thr = 20;
    img[2*W+2] = 250; img[3*W+5] = 0; img[0] = 255; img[6*W+7] = 3; img[1*W+1] = 240;
    run_frame(0, 0);

    // R11: exactly at the margin stays, one above is replaced
    fill(50); thr = 20;
    img[2*W+2] = 70; img[3*W+5] = 71; img[4*W+2] = 29; img[2*W+5] = 30;
    run_frame(20, 20);

    // R4: mixed-sign neighbourhood survives
    fill(100); thr = 20;
    img[2*W+3] = 200; img[4*W+3] = 250; img[3*W+6] = 5; img[5*W+6] = 0;
    run_frame(30, 30);

    // R5: ramps make the pair choice matter
    for (int i = 0; i < NPIX; i++) img[i] = 10 * (i % W) + 3 * (i / W);
    img[3*W+3] = 250; img[2*W+4] = 0; thr = 10;
    run_frame(10, 40);

    // R5 tie order: horizontal and vertical pairs equally flat
    fill(60); thr = 5;
    for (int i = 0; i < NPIX; i++) if ((i / W) % 2 == 0 && (i % W) % 2 == 1) img[i] = 80;
    img[3*W+3] = 200;
    run_frame(0, 50);

    // random sweeps with injected defects, random margins and markers
    for (int f = 0; f < 14; f++) begin
      for (int i = 0; i < NPIX; i++) img[i] = 60 + ($urandom % 80);
      for (int k = 0; k < 6; k++) img[$urandom % NPIX] = ($urandom % 2) ? 255 : ($urandom % 4);
      thr = $urandom % 70;
      if (f % 4 == 3) begin
        for (int i = 0; i < NPIX; i++) begin usr[i] = $urandom % 2; lst[i] = $urandom % 2; end
      end else std_marks();
      run_frame(f * 5 % 60, f * 7 % 70);
      if (hung) break;
    end

    // R6: full random values, zero margin, border-heavy outcomes
    std_marks();
    for (int i = 0; i < NPIX; i++) img[i] = $urandom % 256;
    thr = 0;
    if (!hung) run_frame(25, 25);

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule